// File: doc/BRIEF.md
# Normalized Distance Divider

This block watches a stream of distance samples. It counts how many valid samples arrive and keeps the distance carried by the most recent one. When the end-of-stream strobe is seen, it freezes that count `n` and that distance. It then divides the distance by a divisor that depends on the parity of `n`: `n*n` when `n` is even, and `n*n - 1` when `n` is odd. The result is an integer quotient and remainder.

The division is a serial restoring divider that produces one quotient bit per clock. A divisor of zero occurs for `n = 0` and `n = 1`. No division is run in that case; the result is reported as invalid instead. Each result is announced by a single-cycle `done` pulse. The sample counter is cleared at every end-of-stream, so streams follow one another without any extra control. While a result is being prepared, the block ignores all input strobes.

Top module: `norm_dist_div`

## Requirements
- R1: After a synchronous active-high reset, `res_done`, `res_err`, `res_quot` and `res_rem` are 0 and the sample count is 0, so an end-of-stream strobe given straight after reset reports a zero divisor.
- R2: Each cycle with `smp_valid` high, while the block is idle, raises the count by one. The count saturates at 255. A sample presented in the same cycle as `smp_last` is included in the count.
- R3: Only the distance of the last valid sample before or with `smp_last` is divided. Earlier distances have no effect on the result.
- R4: When the count is even, the divisor is count*count.
- R5: When the count is odd, the divisor is count*count - 1.
- R6: A zero divisor (count 0 or 1) gives `res_err` = 1, `res_quot` = 0 and `res_rem` = 0. In this case `res_done` rises one cycle after the clock edge that samples `smp_last`.
- R7: A nonzero divisor gives `res_err` = 0, the quotient truncated toward zero, and the remainder (which is less than the divisor). `res_done` rises nine cycles after the edge that samples `smp_last`: one cycle to form the divisor and eight cycles of division.
- R8: `res_done` stays high for exactly one cycle per end-of-stream.
- R9: `smp_valid` and `smp_last` are ignored from the edge after `smp_last` is taken until `res_done` rises. They neither change the count nor start another result.
- R10: Taking `smp_last` clears the count, so the next stream starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Qualifies one distance sample |
| smp_dist | input | 8 | Unsigned distance carried by the sample |
| smp_last | input | 1 | End-of-stream strobe |
| res_quot | output | 8 | Quotient, held until the next result |
| res_rem | output | 16 | Remainder, held until the next result |
| res_done | output | 1 | One-cycle pulse when a result is ready |
| res_err | output | 1 | Result invalid (zero divisor), valid with `res_done` |

## Verification
The bench builds the block with its default parameters: an 8-bit distance, an 8-bit count giving a 16-bit divisor, and a saturating counter. The narrow count lets a stream of 260 samples reach the saturation point. That same count (255) gives the largest odd divisor, and the 8-bit dividend makes quotients of zero with large remainders easy to produce. The bench also covers counts of 0 and 1, both parities, gaps between valid samples, and strobes injected during a running division.

// File: rtl/nd_pkg.sv
`timescale 1ns/1ps
package nd_pkg;
   typedef enum logic {
      DV_IDLE = 1'b0,
      DV_RUN  = 1'b1
   } dv_state_t;
endpackage

// File: rtl/sample_tracker.sv
`timescale 1ns/1ps
module sample_tracker #(
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc_smp,
   input  logic              acc_last,
   input  logic [DATA_W-1:0] smp_dist,
   output logic [CNT_W-1:0]  n_hold,
   output logic [DATA_W-1:0] dist_hold
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cnt_inc;
   logic [DATA_W-1:0] dist_live;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
      end else begin : g_wrap
         assign cnt_inc = cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt       <= '0;
         dist_live <= '0;
         n_hold    <= '0;
         dist_hold <= '0;
      end else if (acc_last) begin
         cnt       <= '0;
         n_hold    <= acc_smp ? cnt_inc : cnt;
         dist_hold <= acc_smp ? smp_dist : dist_live;
         if (acc_smp) dist_live <= smp_dist;
      end else if (acc_smp) begin
         cnt       <= cnt_inc;
         dist_live <= smp_dist;
      end
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (acc_smp && !acc_last && cnt != CNT_MAX) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R2
   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
      acc_last |=> cnt == '0); // R10
   AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (!acc_smp && !acc_last) |=> $stable(cnt)); // R9
endmodule

// File: rtl/divisor_gen.sv
`timescale 1ns/1ps
module divisor_gen #(
   parameter int CNT_W = 8,
   localparam int DIV_W = 2 * CNT_W
) (
   input  logic [CNT_W-1:0] n_val,
   output logic [DIV_W-1:0] divisor
);
   logic [DIV_W-1:0] n_ext;
   logic [DIV_W-1:0] sq;

   always_comb begin
      n_ext   = DIV_W'(n_val);
      sq      = n_ext * n_ext;
      divisor = sq - DIV_W'(n_val[0]);
   end
endmodule

// File: rtl/seq_divider.sv
`timescale 1ns/1ps
module seq_divider import nd_pkg::*; #(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [DATA_W-1:0] dividend,
   input  logic [DIV_W-1:0]  divisor,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] quot,
   output logic [DIV_W-1:0]  rem
);
   localparam int SW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [SW-1:0] LAST_STEP = SW'(DATA_W - 1);

   dv_state_t         state;
   logic [DIV_W-1:0]  dvs;
   logic [DIV_W-1:0]  racc;
   logic [DATA_W-1:0] qsh;
   logic [SW-1:0]     step;

   logic [DIV_W:0]    shifted;
   logic              ge;
   logic [DIV_W-1:0]  rem_next;

   always_comb begin
      shifted  = {racc, qsh[DATA_W-1]};
      ge       = shifted >= {1'b0, dvs};
      rem_next = ge ? (shifted[DIV_W-1:0] - dvs) : shifted[DIV_W-1:0];
   end

   assign busy = (state == DV_RUN);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= DV_IDLE;
         dvs   <= '0;
         racc  <= '0;
         qsh   <= '0;
         step  <= '0;
         done  <= 1'b0;
         err   <= 1'b0;
         quot  <= '0;
         rem   <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            DV_IDLE: if (start) begin
               if (divisor == '0) begin
                  done <= 1'b1;
                  err  <= 1'b1;
                  quot <= '0;
                  rem  <= '0;
               end else begin
                  state <= DV_RUN;
                  dvs   <= divisor;
                  racc  <= '0;
                  qsh   <= dividend;
                  step  <= '0;
               end
            end
            DV_RUN: begin
               racc <= rem_next;
               qsh  <= {qsh[DATA_W-2:0], ge};
               step <= step + 1'b1;
               if (step == LAST_STEP) begin
                  state <= DV_IDLE;
                  done  <= 1'b1;
                  err   <= 1'b0;
                  quot  <= {qsh[DATA_W-2:0], ge};
                  rem   <= rem_next;
               end
            end
            default: state <= DV_IDLE;
         endcase
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R8
   AST_ZERO_ERR: assert property (@(posedge clk) disable iff (rst)
      (start && !busy && divisor == '0) |=> (done && err && quot == '0)); // R6
   AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
      (done && !err) |-> rem < dvs); // R7
endmodule

// File: rtl/norm_dist_div.sv
`timescale 1ns/1ps
module norm_dist_div #(
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1,
   localparam int DIV_W   = 2 * CNT_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_dist,
   input  logic              smp_last,
   output logic [DATA_W-1:0] res_quot,
   output logic [DIV_W-1:0]  res_rem,
   output logic              res_done,
   output logic              res_err
);
   initial begin
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
      assert (CNT_W >= 1) else $error("CNT_W must be at least 1");
   end

   logic              prep;
   logic              busy;
   logic              div_busy;
   logic              acc_smp;
   logic              acc_last;
   logic [CNT_W-1:0]  n_hold;
   logic [DATA_W-1:0] dist_hold;
   logic [DIV_W-1:0]  divisor;

   assign busy     = prep | div_busy;
   assign acc_smp  = smp_valid & ~busy;
   assign acc_last = smp_last & ~busy;

   always_ff @(posedge clk) begin
      if (rst) prep <= 1'b0;
      else     prep <= acc_last;
   end

   sample_tracker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SATURATE(SATURATE)) i_track (
      .clk       (clk),
      .rst       (rst),
      .acc_smp   (acc_smp),
      .acc_last  (acc_last),
      .smp_dist  (smp_dist),
      .n_hold    (n_hold),
      .dist_hold (dist_hold)
   );

   divisor_gen #(.CNT_W(CNT_W)) i_dvgen (
      .n_val   (n_hold),
      .divisor (divisor)
   );

   seq_divider #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_div (
      .clk      (clk),
      .rst      (rst),
      .start    (prep),
      .dividend (dist_hold),
      .divisor  (divisor),
      .busy     (div_busy),
      .done     (res_done),
      .err      (res_err),
      .quot     (res_quot),
      .rem      (res_rem)
   );

   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
      busy |=> ($stable(n_hold) && $stable(dist_hold))); // R9
   AST_ERR_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
      (prep && n_hold <= CNT_W'(1)) |=> (res_done && res_err)); // R6
endmodule

// File: tb/test_norm_dist_div.sv
`timescale 1ns/1ps
module test_norm_dist_div;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        smp_valid = 1'b0;
   logic [7:0]  smp_dist = '0;
   logic        smp_last = 1'b0;
   logic [7:0]  res_quot;
   logic [15:0] res_rem;
   logic        res_done;
   logic        res_err;

   int compared = 0;
   int mismatched = 0;

   typedef struct {
      int    q;
      int    r;
      int    e;
      int    lat;
      string tag;
      real   t0;
   } exp_t;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   norm_dist_div i_norm_dist_div (
      .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_dist(smp_dist),
      .smp_last(smp_last), .res_quot(res_quot), .res_rem(res_rem),
      .res_done(res_done), .res_err(res_err)
   );

   task automatic chk(string req, string what, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: pop expected result on each done pulse (R8: extra pulse -> unexpected)
   always @(negedge clk) begin
      if (!rst && res_done) begin
         if (sb_q.size() == 0) begin
            compared++;
            mismatched++;
            $display("FAIL R8 unexpected done: actual 1 expected 0");
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.tag, "quotient", int'(res_quot), e.q);
            chk(e.tag, "remainder", int'(res_rem), e.r);
            chk(e.tag, "error flag", int'(res_err), e.e);
            chk(e.e ? "R6" : "R7", "latency x0.1ns", int'(($realtime - e.t0) * 10.0), e.lat);
         end
      end
   end

   // driver: n samples, final one carries fin and the last strobe
   task automatic send_stream(int n, int fin, bit gaps, bit interfere, string tag);
      int ne, dv;
      exp_t e;
      for (int i = 0; i < n; i++) begin
         if (gaps && (i % 3 == 1)) begin
            @(negedge clk);
            smp_valid = 1'b0; smp_last = 1'b0; smp_dist = 8'hEE;
         end
         @(negedge clk);
         smp_valid = 1'b1;
         smp_dist  = (i == n - 1) ? 8'(fin) : 8'((i * 37 + 11) & 255);
         smp_last  = (i == n - 1);
      end
      if (n == 0) begin
         @(negedge clk);
         smp_valid = 1'b0; smp_last = 1'b1;
      end
      ne = (n > 255) ? 255 : n;
      dv = (ne % 2 == 0) ? ne * ne : ne * ne - 1;
      @(posedge clk);
      e.tag = tag;
      e.t0  = $realtime;
      if (dv == 0) begin
         e.q = 0; e.r = 0; e.e = 1; e.lat = 75;
      end else begin
         e.q = fin / dv; e.r = fin % dv; e.e = 0; e.lat = 475;
      end
      sb_q.push_back(e);
      @(negedge clk);
      smp_valid = 1'b0; smp_last = 1'b0;
      if (interfere) begin
         for (int k = 0; k < 6; k++) begin
            smp_valid = 1'b1; smp_dist = 8'd99; smp_last = (k == 3);
            @(negedge clk);
         end
         smp_valid = 1'b0; smp_last = 1'b0;
      end
      wait (sb_q.size() == 0);
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "done after reset", int'(res_done), 0);
      chk("R1", "err after reset", int'(res_err), 0);
      chk("R1", "quot after reset", int'(res_quot), 0);
      chk("R1", "rem after reset", int'(res_rem), 0);
      send_stream(0, 0, 1'b0, 1'b0, "R1");     // empty count -> zero divisor
      send_stream(1, 77, 1'b0, 1'b0, "R6");    // n=1 -> 0 divisor
      send_stream(4, 200, 1'b0, 1'b0, "R4");   // 200/16 = 12 r 8
      send_stream(3, 250, 1'b0, 1'b0, "R5");   // 250/8  = 31 r 2
      send_stream(2, 255, 1'b0, 1'b0, "R4");   // 255/4  = 63 r 3
      send_stream(5, 100, 1'b1, 1'b0, "R2");   // gaps; 100/24 = 4 r 4
      send_stream(10, 201, 1'b1, 1'b0, "R3");  // 201/100 = 2 r 1
      send_stream(3, 7, 1'b0, 1'b1, "R9");     // strobes during division ignored
      send_stream(2, 9, 1'b0, 1'b0, "R10");    // fresh count: 9/4 = 2 r 1
      send_stream(16, 255, 1'b0, 1'b0, "R7");  // 255/256 = 0 r 255
      send_stream(260, 254, 1'b0, 1'b0, "R2"); // saturates at 255: 254/65024
      send_stream(7, 48, 1'b0, 1'b0, "R5");    // 48/48 = 1 r 0
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule